// File: doc/BRIEF.md
# Two-Wire Command Slave for a Digital Potentiometer

This block is the serial front end of a single digitally controlled potentiometer. A system clock oversamples the two-wire bus lines. The block finds bus start and stop conditions and checks the address byte against a fixed device type and three strap pins. It then decodes an instruction byte that holds an operation code and a pointer to one of four stored settings.

Read and write commands move a 10-bit value in two data bytes. The first data byte carries only the two top value bits in its low end. Transfer commands end right after the instruction byte. The block has no storage of its own. It sends a single-cycle command strobe to a separate register bank. It takes read data from that bank. It reads the bank's nonvolatile-busy flag, so that a master can poll for the end of a slow write.

The serial data line is driven only low, through an open-drain enable. A high enable means the pin is pulled low.

Top module: `dpot_cmd_slave`

## Requirements
- R1: A falling edge on SDA while SCL is high starts an address byte. A rising edge on SDA while SCL is high returns the block to idle. Either condition in the middle of a transaction abandons it, and no command strobe is issued.
- R2: The address byte is sent MSB first: bits 7:4 are 0101, bits 3:1 equal `strap_i`, and bit 0 is R/W (1 means read). On a match the slave pulls SDA low for the ninth clock. On a mismatch it gives no acknowledge and stays silent until the next start.
- R3: If `nv_busy_i` is high when the address byte ends, the slave does not acknowledge it.
- R4: The instruction byte has bits 7:5 = opcode, bit 4 = 0, bits 3:2 = register pointer and bits 1:0 = 0. These R/W and opcode pairs are legal: 1/100, 0/101, 1/101, 0/110, 1/110 and 0/111. Any other pair, or a nonzero reserved bit, gets no acknowledge, and the block returns to idle.
- R5: With R/W=0 and opcode 101 (set wiper) or 110 (store setting), two data bytes follow, and the slave acknowledges each one. Only bits 1:0 of the first byte are kept, as value bits 9:8. The second byte gives bits 7:0. After the second acknowledge, one strobe is issued with `cmd_op_o` = 1 (set wiper) or 2 (store setting), together with the pointer and the value.
- R6: With R/W=1 and opcode 100 (wiper) or 101 (setting), the slave shifts out 16 bits MSB first. The first byte is six zeros followed by bits 9:8; the second byte is bits 7:0. The value is taken from `wcr_i` or `dr_i` at the end of the instruction acknowledge. If the master does not acknowledge a byte, the read ends and SDA is released. A read issues no strobe.
- R7: A transfer from setting to wiper (R/W=1, opcode 110) issues `cmd_op_o` = 3. A transfer from wiper to setting (R/W=0, opcode 111) issues `cmd_op_o` = 4. In both cases the strobe comes at the end of the instruction acknowledge clock, carries the pointer, and no data bytes follow.
- R8: The SDA drive enable changes only after a detected SCL falling edge, or on a start or stop condition.
- R9: After reset, SDA is released and no strobe is pending. `cmd_valid_o` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe_o | output | 1 | Pull SDA low when high |
| strap_i | input | 3 | Strap pins for the low address bits |
| nv_busy_i | input | 1 | Register bank is in a nonvolatile write |
| wcr_i | input | 10 | Current wiper value from the bank |
| dr_i | input | 10 | Stored setting selected by reg_ptr_o |
| reg_ptr_o | output | 2 | Pointer of the current instruction |
| cmd_valid_o | output | 1 | Single-cycle command strobe |
| cmd_op_o | output | 3 | Command: 1 set wiper, 2 store setting, 3 setting to wiper, 4 wiper to setting |
| cmd_ptr_o | output | 2 | Register pointer for the command |
| cmd_data_o | output | 10 | Value for the set and store commands |

## Verification
The assertions assume that the bus lines move slowly compared with the system clock, so that each SCL phase lasts several clock cycles after synchronization. They also assume that SDA changes only while SCL is low, except when it forms a start or stop condition. The bench master holds every bus phase for eight clock cycles and changes SDA in the middle of the SCL low phase. Its bank model raises the busy flag for a fixed number of cycles after each store strobe, and that flag is the only source of the block's busy input.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    localparam logic [3:0] DEV_TYPE = 4'b0101;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_WR_WCR = 3'd1,
        OP_WR_DR  = 3'd2,
        OP_DR2WCR = 3'd3,
        OP_WCR2DR = 3'd4,
        OP_RD_WCR = 3'd5,
        OP_RD_DR  = 3'd6
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ACK_ADDR,
        S_INSTR,
        S_ACK_INSTR,
        S_WDATA,
        S_ACK_W,
        S_RDATA,
        S_ACK_R
    } state_e;
endpackage

// File: rtl/dpot_bus_sync.sv
module dpot_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES:0] scl;
        logic [STAGES:0] sda;
    } sh_t;

    sh_t sh_d, sh_q;
    logic scl_now, scl_old, sda_now, sda_old;

    always_comb begin
        sh_d     = sh_q;
        sh_d.scl = {sh_q.scl[STAGES-1:0], scl_i};
        sh_d.sda = {sh_q.sda[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign scl_now    = sh_q.scl[STAGES-1];
    assign scl_old    = sh_q.scl[STAGES];
    assign sda_now    = sh_q.sda[STAGES-1];
    assign sda_old    = sh_q.sda[STAGES];
    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/dpot_instr_decode.sv
module dpot_instr_decode
    import dpot_pkg::*;
(
    input  logic       rw_i,
    input  logic [7:0] instr_i,
    output op_e        op_o,
    output logic [1:0] ptr_o,
    output logic       legal_o
);
    always_comb begin
        op_o  = OP_NONE;
        ptr_o = instr_i[3:2];
        if (!instr_i[4] && (instr_i[1:0] == 2'b00)) begin
            unique case ({rw_i, instr_i[7:5]})
                4'b1100: op_o = OP_RD_WCR;
                4'b0101: op_o = OP_WR_WCR;
                4'b1101: op_o = OP_RD_DR;
                4'b0110: op_o = OP_WR_DR;
                4'b1110: op_o = OP_DR2WCR;
                4'b0111: op_o = OP_WCR2DR;
                default: op_o = OP_NONE;
            endcase
        end
        legal_o = (op_o != OP_NONE);
    end
endmodule

// File: rtl/dpot_cmd_slave.sv
module dpot_cmd_slave
    import dpot_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int PTR_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    input  logic              nv_busy_i,
    input  logic [DATA_W-1:0] wcr_i,
    input  logic [DATA_W-1:0] dr_i,
    output logic [PTR_W-1:0]  reg_ptr_o,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_op_o,
    output logic [PTR_W-1:0]  cmd_ptr_o,
    output logic [DATA_W-1:0] cmd_data_o
);
    localparam int HI_W = DATA_W - 8;
    localparam int PAD_W = 8 - HI_W;

    typedef struct packed {
        state_e            state;
        logic [3:0]        bitc;
        logic              byte_sel;
        logic [7:0]        sr;
        logic              rw;
        op_e               op;
        logic [PTR_W-1:0]  ptr;
        logic [DATA_W-1:0] data;
        logic              mack;
        logic              oe;
        logic              vld;
    } st_t;

    st_t d, q;

    logic sda_s, scl_rise, scl_fall, start, stop;
    op_e  dec_op;
    logic [1:0] dec_ptr;
    logic dec_legal;
    logic [DATA_W-1:0] rdval;
    logic [7:0] first_rd;

    dpot_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start),
        .stop_o     (stop)
    );

    dpot_instr_decode u_dec (
        .rw_i    (q.rw),
        .instr_i (q.sr),
        .op_o    (dec_op),
        .ptr_o   (dec_ptr),
        .legal_o (dec_legal)
    );

    assign rdval    = (q.op == OP_RD_WCR) ? wcr_i : dr_i;
    assign first_rd = {{PAD_W{1'b0}}, rdval[DATA_W-1:8]};

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (start) begin
            d.state = S_ADDR;
            d.bitc  = 4'd0;
            d.oe    = 1'b0;
        end else if (stop) begin
            d.state = S_IDLE;
            d.oe    = 1'b0;
        end else begin
            unique case (q.state)
                S_ADDR, S_INSTR, S_WDATA: begin
                    if (scl_rise && q.bitc < 4'd8) begin
                        d.sr   = {q.sr[6:0], sda_s};
                        d.bitc = q.bitc + 4'd1;
                    end else if (scl_fall && q.bitc == 4'd8) begin
                        d.bitc = 4'd0;
                        if (q.state == S_ADDR) begin
                            if (q.sr[7:1] == {DEV_TYPE, strap_i} && !nv_busy_i) begin
                                d.state = S_ACK_ADDR;
                                d.oe    = 1'b1;
                                d.rw    = q.sr[0];
                            end else begin
                                d.state = S_IDLE;
                            end
                        end else if (q.state == S_INSTR) begin
                            if (dec_legal) begin
                                d.state = S_ACK_INSTR;
                                d.oe    = 1'b1;
                                d.op    = dec_op;
                                d.ptr   = PTR_W'(dec_ptr);
                            end else begin
                                d.state = S_IDLE;
                            end
                        end else begin
                            if (!q.byte_sel) d.data[DATA_W-1:8] = q.sr[HI_W-1:0];
                            else             d.data[7:0]        = q.sr;
                            d.state = S_ACK_W;
                            d.oe    = 1'b1;
                        end
                    end
                end
                S_ACK_ADDR: begin
                    if (scl_fall) begin
                        d.oe    = 1'b0;
                        d.state = S_INSTR;
                    end
                end
                S_ACK_INSTR: begin
                    if (scl_fall) begin
                        d.oe       = 1'b0;
                        d.bitc     = 4'd0;
                        d.byte_sel = 1'b0;
                        if (q.op == OP_DR2WCR || q.op == OP_WCR2DR) begin
                            d.vld   = 1'b1;
                            d.state = S_IDLE;
                        end else if (q.op == OP_WR_WCR || q.op == OP_WR_DR) begin
                            d.state = S_WDATA;
                        end else begin
                            d.data  = rdval;
                            d.sr    = first_rd;
                            d.oe    = ~first_rd[7];
                            d.state = S_RDATA;
                        end
                    end
                end
                S_ACK_W: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        if (q.byte_sel) begin
                            d.vld   = 1'b1;
                            d.state = S_IDLE;
                        end else begin
                            d.byte_sel = 1'b1;
                            d.state    = S_WDATA;
                        end
                    end
                end
                S_RDATA: begin
                    if (scl_rise) begin
                        d.bitc = q.bitc + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitc == 4'd8) begin
                            d.oe    = 1'b0;
                            d.state = S_ACK_R;
                        end else begin
                            d.sr = {q.sr[6:0], 1'b0};
                            d.oe = ~q.sr[6];
                        end
                    end
                end
                S_ACK_R: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack && !q.byte_sel) begin
                            d.sr       = q.data[7:0];
                            d.oe       = ~q.data[7];
                            d.byte_sel = 1'b1;
                            d.bitc     = 4'd0;
                            d.state    = S_RDATA;
                        end else begin
                            d.oe    = 1'b0;
                            d.state = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.op    <= OP_NONE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.oe;
    assign reg_ptr_o   = q.ptr;
    assign cmd_valid_o = q.vld;
    assign cmd_op_o    = q.op;
    assign cmd_ptr_o   = q.ptr;
    assign cmd_data_o  = q.data;

    state_e st_q;
    assign st_q = q.state;

    assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    assert_strobe_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> ($past(st_q) == S_ACK_W || $past(st_q) == S_ACK_INSTR));

    assert_oe_after_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $past(scl_fall || start || stop));

    assert_busy_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_ACK_ADDR && $past(st_q) == S_ADDR) |-> $past(!nv_busy_i));

    assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE) |-> !sda_oe_o);

    assert_instr_ack_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_ACK_INSTR && $past(st_q) == S_INSTR) |-> (cmd_op_o != 3'd0));
endmodule

// File: tb/dpot_cmd_slave_bench.sv
module dpot_cmd_slave_bench;
    localparam int QTR = 8;
    localparam int BUSY_CYC = 1500;
    localparam logic [2:0] STRAP = 3'b110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_line, sda_oe;
    logic nv_busy;
    logic [9:0] wcr_m, dr_rd;
    logic [9:0] dr_m [4];
    logic [1:0] reg_ptr, cmd_ptr;
    logic cmd_valid;
    logic [2:0] cmd_op;
    logic [9:0] cmd_data;
    int busy_cnt;
    int n_strobe, n_chk, n_fail;
    logic [2:0] last_op;
    logic [1:0] last_ptr;
    logic [9:0] last_data;
    logic [9:0] exp_wcr;
    logic [9:0] exp_dr [4];
    bit done;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;
    assign nv_busy  = (busy_cnt != 0);
    assign dr_rd    = dr_m[reg_ptr];

    dpot_cmd_slave u_dpot_cmd_slave (
        .clk (clk), .rst_n (rst_n), .scl_i (m_scl), .sda_i (sda_line),
        .sda_oe_o (sda_oe), .strap_i (STRAP), .nv_busy_i (nv_busy),
        .wcr_i (wcr_m), .dr_i (dr_rd), .reg_ptr_o (reg_ptr),
        .cmd_valid_o (cmd_valid), .cmd_op_o (cmd_op), .cmd_ptr_o (cmd_ptr),
        .cmd_data_o (cmd_data)
    );

    // register bank model driven only by strobes
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcr_m <= '0;
            for (int i = 0; i < 4; i++) dr_m[i] <= '0;
            busy_cnt <= 0; n_strobe <= 0;
            last_op <= '0; last_ptr <= '0; last_data <= '0;
        end else begin
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if (cmd_valid) begin
                n_strobe  <= n_strobe + 1;
                last_op   <= cmd_op;
                last_ptr  <= cmd_ptr;
                last_data <= cmd_data;
                case (cmd_op)
                    3'd1: wcr_m <= cmd_data;
                    3'd2: begin dr_m[cmd_ptr] <= cmd_data; busy_cnt <= BUSY_CYC; end
                    3'd3: wcr_m <= dr_m[cmd_ptr];
                    3'd4: begin dr_m[cmd_ptr] <= wcr_m; busy_cnt <= BUSY_CYC; end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic exp_instr_ack(input logic rw, input logic [7:0] ins);
        logic [3:0] k;
        k = {rw, ins[7:5]};
        if (ins[4] || ins[1:0] != 2'b00) return 1'b0;
        return (k == 4'b1100 || k == 4'b0101 || k == 4'b1101 ||
                k == 4'b0110 || k == 4'b1110 || k == 4'b0111);
    endfunction

    function automatic logic [7:0] exp_first_byte(input logic [9:0] v);
        return {6'b0, v[9:8]};
    endfunction

    function automatic logic [7:0] instr(input logic [2:0] opc, input logic [1:0] p);
        return {opc, 1'b0, p, 2'b00};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n * QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1); m_sda = 1'b0; qw(1); m_scl = 1'b0; qw(1);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw(1); m_scl = 1'b1; qw(1); m_sda = 1'b1; qw(1);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; qw(1); m_scl = 1'b1; qw(2); m_scl = 1'b0; qw(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1); ack = ~sda_line; qw(1); m_scl = 1'b0; qw(1);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1); b[i] = sda_line; qw(1); m_scl = 1'b0; qw(1);
        end
        send_bit(~mack);
        m_sda = 1'b1;
    endtask

    task automatic wr4(input logic [7:0] ins, input logic [9:0] v, output logic ok);
        logic a0, a1, a2, a3;
        logic [5:0] pad;
        pad = 6'($urandom);
        bus_start();
        send_byte({4'b0101, STRAP, 1'b0}, a0);
        send_byte(ins, a1);
        send_byte({pad, v[9:8]}, a2);
        send_byte(v[7:0], a3);
        bus_stop();
        ok = a0 & a1 & a2 & a3;
    endtask

    task automatic rd4(input logic [7:0] ins, output logic [9:0] v, output logic [7:0] b0,
                       output logic ok);
        logic a0, a1;
        logic [7:0] b1;
        bus_start();
        send_byte({4'b0101, STRAP, 1'b1}, a0);
        send_byte(ins, a1);
        recv_byte(1'b1, b0);
        recv_byte(1'b0, b1);
        bus_stop();
        v  = {b0[1:0], b1};
        ok = a0 & a1;
    endtask

    task automatic xf2(input logic [7:0] ins, input logic rw, output logic a0, output logic a1);
        bus_start();
        send_byte({4'b0101, STRAP, rw}, a0);
        send_byte(ins, a1);
        bus_stop();
    endtask

    task automatic wait_ready(output int polls);
        logic a;
        polls = 0;
        for (int i = 0; i < 60; i++) begin
            bus_start();
            send_byte({4'b0101, STRAP, 1'b0}, a);
            bus_stop();
            if (a) break;
            polls++;
        end
    endtask

    task automatic read_check(input string req, input logic [7:0] ins, input logic [9:0] ev);
        logic [9:0] v;
        logic [7:0] b0;
        logic ok;
        rd4(ins, v, b0, ok);
        chk(req, ok, 1);
        chk(req, b0, exp_first_byte(ev));
        chk(req, v, ev);
    endtask

    initial begin
        logic ok, a0, a1, a2;
        logic [9:0] v;
        logic [7:0] b0, b1;
        int polls, s0;
        void'($urandom(32'd1234));
        n_chk = 0; n_fail = 0;
        exp_wcr = '0;
        for (int i = 0; i < 4; i++) exp_dr[i] = '0;
        repeat (10) @(negedge clk);
        chk("R9 reset strobe", cmd_valid, 0);
        chk("R9 reset sda released", sda_oe, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R2: wrong strap address gets no acknowledge and no command
        s0 = n_strobe;
        bus_start();
        send_byte({4'b0101, ~STRAP, 1'b0}, a0);
        send_byte(instr(3'b101, 2'b00), a1);
        bus_stop();
        chk("R2 mismatch addr ack", a0, 0);
        chk("R2 ignored after mismatch", a1, 0);
        chk("R2 no strobe", n_strobe - s0, 0);
        // R2: wrong device type nibble
        bus_start();
        send_byte({4'b0110, STRAP, 1'b0}, a0);
        bus_stop();
        chk("R2 type mismatch", a0, 0);

        // R5: set wiper
        s0 = n_strobe;
        wr4(instr(3'b101, 2'b00), 10'h2A5, ok);
        exp_wcr = 10'h2A5;
        chk("R5 write acks", ok, 1);
        chk("R5 one strobe", n_strobe - s0, 1);
        chk("R5 op", last_op, 1);
        chk("R5 data", last_data, 10'h2A5);
        read_check("R6 read wiper", instr(3'b100, 2'b00), exp_wcr);

        // R5 + R3: store settings, poll for busy
        for (int p = 0; p < 4; p++) begin
            v = 10'(p * 259 + 17);
            wr4(instr(3'b110, 2'(p)), v, ok);
            exp_dr[p] = v;
            chk("R5 store acks", ok, 1);
            chk("R5 store op", last_op, 2);
            chk("R5 store ptr", last_ptr, p);
            bus_start();
            send_byte({4'b0101, STRAP, 1'b0}, a0);
            bus_stop();
            chk("R3 busy nack", a0, 0);
            wait_ready(polls);
            chk("R3 ready eventually", (polls < 60) ? 1 : 0, 1);
        end
        for (int p = 0; p < 4; p++) read_check("R6 read setting", instr(3'b101, 2'(p)), exp_dr[p]);

        // R7: transfers
        s0 = n_strobe;
        xf2(instr(3'b110, 2'd2), 1'b1, a0, a1);
        exp_wcr = exp_dr[2];
        chk("R7 xfer ack", a0 & a1, 1);
        chk("R7 xfer op", last_op, 3);
        chk("R7 xfer ptr", last_ptr, 2);
        chk("R7 single strobe", n_strobe - s0, 1);
        read_check("R7 wiper after load", instr(3'b100, 2'b00), exp_wcr);
        xf2(instr(3'b111, 2'd1), 1'b0, a0, a1);
        exp_dr[1] = exp_wcr;
        chk("R7 save op", last_op, 4);
        wait_ready(polls);
        read_check("R7 setting after save", instr(3'b101, 2'd1), exp_dr[1]);

        // R4: illegal instruction bytes
        s0 = n_strobe;
        xf2(instr(3'b100, 2'd0), 1'b0, a0, a1);
        chk("R4 bad pair ack", a1, exp_instr_ack(1'b0, instr(3'b100, 2'd0)));
        xf2(instr(3'b111, 2'd0), 1'b1, a0, a1);
        chk("R4 bad pair read", a1, 0);
        xf2(instr(3'b110, 2'd0) | 8'h10, 1'b1, a0, a1);
        chk("R4 reserved bit4", a1, 0);
        xf2(instr(3'b110, 2'd3) | 8'h01, 1'b1, a0, a1);
        chk("R4 reserved bit0", a1, 0);
        chk("R4 no strobe", n_strobe - s0, 0);

        // R1: stop after first data byte abandons the write
        s0 = n_strobe;
        bus_start();
        send_byte({4'b0101, STRAP, 1'b0}, a0);
        send_byte(instr(3'b101, 2'b00), a1);
        send_byte(8'h01, a2);
        bus_stop();
        chk("R1 stop abort no strobe", n_strobe - s0, 0);
        // R1: repeated start mid second byte
        bus_start();
        send_byte({4'b0101, STRAP, 1'b0}, a0);
        send_byte(instr(3'b101, 2'b00), a1);
        send_byte(8'h03, a2);
        send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte({4'b0101, STRAP, 1'b1}, a0);
        chk("R1 restart addr ack", a0, 1);
        bus_stop();
        chk("R1 restart abort no strobe", n_strobe - s0, 0);
        read_check("R1 wiper unchanged", instr(3'b100, 2'b00), exp_wcr);

        // R6: master NACK after first byte ends the read
        bus_start();
        send_byte({4'b0101, STRAP, 1'b1}, a0);
        send_byte(instr(3'b100, 2'b00), a1);
        recv_byte(1'b0, b0);
        recv_byte(1'b0, b1);
        bus_stop();
        chk("R6 nack first byte", b0, exp_first_byte(exp_wcr));
        chk("R6 released after nack", b1, 8'hFF);

        // random mix
        for (int it = 0; it < 24; it++) begin
            int kind;
            logic [1:0] p;
            logic [9:0] rv;
            logic nv;
            kind = int'($urandom % 6);
            p  = 2'($urandom);
            rv = 10'($urandom);
            nv = 1'b0;
            case (kind)
                0: begin wr4(instr(3'b101, 2'b00), rv, ok); exp_wcr = rv; chk("R5 rand wiper", ok, 1); end
                1: begin wr4(instr(3'b110, p), rv, ok); exp_dr[p] = rv; nv = 1'b1; chk("R5 rand store", ok, 1); end
                2: read_check("R6 rand wiper", instr(3'b100, 2'b00), exp_wcr);
                3: read_check("R6 rand setting", instr(3'b101, p), exp_dr[p]);
                4: begin xf2(instr(3'b110, p), 1'b1, a0, a1); exp_wcr = exp_dr[p]; chk("R7 rand load", a1, 1); end
                default: begin xf2(instr(3'b111, p), 1'b0, a0, a1); exp_dr[p] = exp_wcr; nv = 1'b1; chk("R7 rand save", a1, 1); end
            endcase
            if (nv) wait_ready(polls);
        end
        read_check("R6 final wiper", instr(3'b100, 2'b00), exp_wcr);
        for (int p = 0; p < 4; p++) read_check("R6 final setting", instr(3'b101, 2'(p)), exp_dr[p]);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule